// File: doc/BRIEF.md
# Synchronous Serial Receive Controller

This block is the receive half of a clocked synchronous serial port. It can act as clock master or as clock slave. It gathers 8-bit frames from a serial data line into a receive data register. It flags each finished frame to the host, can raise an interrupt for it, and detects overrun. A small host register bus exposes three registers: the received byte, a status register, and a control register. Reads take effect on the clock edge at which `host_rd` is high. `host_rdata` is combinational and shows the register value before that edge.

In master mode the block does not clock continuously. Each host read of the data register, made while the block is idle, runs exactly one frame of eight serial clock pulses. The first such read is a dummy read that only starts reception. A stop control bit lets the host request one last frame and then halt the clock, so the final byte can be read without producing more clocks. In slave mode the block drives no clock. It samples the data line on rising edges of an external clock, after bringing that clock and the data into the system clock domain.

An overrun freezes reception until software clears the error flag. The host registers are plain control and status access; the block has no streaming interface, and the host paces the data by reading.

Top module: `ssrx_ctrl`

## Requirements
- R1: A frame is 8 bits, received most significant bit first and sampled on rising serial clock edges. When the eighth bit arrives, the byte appears in the data register (address 0) and the full flag (status address 1, bit 0) becomes 1.
- R2: `irq_rx` is high exactly while the full flag is 1 and the receive interrupt enable (control address 2, bit 3) is 1.
- R3: A read of the data register clears the full flag. If a frame completes in the same cycle as the read, the read returns the previous byte, the new byte is loaded, the full flag stays 1, and no overrun is recorded.
- R4: In master mode (control bit 1 = 1, enable bit 0 = 1), a data register read made while no frame is in progress starts one frame of exactly 8 clock pulses on `sck_out`. The clock period is 4 system clocks with 50% duty, and the clock idles high. A read made while a frame is in progress starts nothing.
- R5: If the stop bit (control bit 2) is 1 when a read starts a frame, that frame is the last one. Later reads produce no clock pulses until the stop bit or the enable bit is cleared.
- R6: If a frame completes while the full flag is 1 and no read happens in that cycle, the overrun flag (status bit 1) is set and the data register keeps its old byte. `irq_ovr` is high while overrun is 1 and the overrun interrupt enable (control bit 4) is 1.
- R7: While the overrun flag is 1, no frame is received and the full flag is not set. A status write with bit 1 = 0 clears the overrun flag. A status write with bit 1 = 1 leaves it unchanged.
- R8: In slave mode (control bit 1 = 0), `sck_oe` is 0. `sdi` is sampled on rising edges of `sck_in`, after both signals pass through a two-stage synchronizer.
- R9: Clearing the enable bit discards any partial frame and resets the bit count. In master mode it also stops the clock with `sck_out` high.
- R10: After reset, the status and control registers read 0, `sck_out` is 1, `sck_oe` is 0, and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Register select: 0 data, 1 status, 2 control |
| host_rd | input | 1 | Read strobe; side effects happen at the clock edge |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected register (combinational) |
| sck_in | input | 1 | External serial clock in slave mode |
| sck_out | output | 1 | Generated serial clock in master mode, idles high |
| sck_oe | output | 1 | High when `sck_out` should drive the line |
| sdi | input | 1 | Serial data input |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_ovr | output | 1 | Overrun interrupt request |

## Verification
Two events can land on the same edge: a host read that clears the full flag, and the completion of the next frame, which either sets full or records an overrun. In slave mode the bench places the read strobe on exactly the edge at which the synchronized eighth rising edge completes the frame. It then expects three things: the read returns the earlier byte, the full flag stays set, and no overrun appears. In the contrasting case, a frame that completes with no read in that cycle, the bench expects the overrun flag and the old byte to remain.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_CTRL = 2'd2
  } reg_sel_e;

  localparam int unsigned STS_FULL = 0;
  localparam int unsigned STS_OVR  = 1;

  // packed order puts en at bit 0, ovie at bit 4
  typedef struct packed {
    logic ovie;
    logic rxie;
    logic stop;
    logic master;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ssrx_sclk_gen.sv
module ssrx_sclk_gen #(
  parameter int unsigned DIV_HALF   = 2,
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic rise,
  output logic frame_end
);
  localparam int unsigned PH_W  = $clog2(2 * DIV_HALF);
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);
  localparam logic [PH_W-1:0]  PH_RISE = PH_W'(DIV_HALF - 1);
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(2 * DIV_HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic [PH_W-1:0]  ph;
  logic [BIT_W-1:0] bitn;

  assign rise      = busy && !abort && (ph == PH_RISE);
  assign frame_end = busy && !abort && (ph == PH_LAST) && (bitn == BIT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph   <= '0;
      bitn <= '0;
      sck  <= 1'b1;
    end else if (abort) begin
      busy <= 1'b0;
      ph   <= '0;
      bitn <= '0;
      sck  <= 1'b1;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        ph   <= '0;
        bitn <= '0;
        sck  <= 1'b0;
      end
    end else if (ph == PH_LAST) begin
      ph <= '0;
      if (bitn == BIT_LAST) begin
        busy <= 1'b0;
        bitn <= '0;
      end else begin
        bitn <= bitn + 1'b1;
        sck  <= 1'b0;
      end
    end else begin
      ph <= ph + 1'b1;
      if (ph == PH_RISE) sck <= 1'b1;
    end
  end

  // R4
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  // R4
  rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $past(rise) || $past(abort));
endmodule

// File: rtl/ssrx_in_sync.sv
module ssrx_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi_in,
  output logic rise,
  output logic bit_o
);
  logic [STAGES-1:0] sck_p;
  logic [STAGES-1:0] sdi_p;
  logic              sck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_p    <= '1;
      sdi_p    <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_p    <= {sck_p[STAGES-2:0], sck_in};
      sdi_p    <= {sdi_p[STAGES-2:0], sdi_in};
      sck_prev <= sck_p[STAGES-1];
    end
  end

  assign rise  = sck_p[STAGES-1] && !sck_prev;
  assign bit_o = sdi_p[STAGES-1];

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/ssrx_shifter.sv
module ssrx_shifter #(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  hold,
  input  logic                  rise,
  input  logic                  bit_in,
  output logic                  done,
  output logic [FRAME_BITS-1:0] word
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      cnt;
  logic                  take;

  assign take = rise && !hold && !clear;
  assign done = take && (cnt == CNT_LAST);
  assign word = {sh[FRAME_BITS-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clear) begin
      sh  <= '0;
      cnt <= '0;
    end else if (take) begin
      sh  <= word;
      cnt <= done ? '0 : cnt + 1'b1;
    end
  end

  // R9
  clear_resets_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> cnt == '0);

  // R7
  hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold && !clear |=> $stable(cnt) && $stable(sh));
endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
  import ssrx_pkg::*;
#(
  parameter int unsigned DIV_HALF    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sck_oe,
  input  logic              sdi,
  output logic              irq_rx,
  output logic              irq_ovr
);
  ctrl_t             ctrl;
  logic [BYTE_W-1:0] rx_data;
  logic              full, ovr, halted, last_frm;

  logic data_rd, stat_wr, ctrl_wr, ovr_clr;
  logic m_start, m_abort, m_busy, m_sck, m_rise, m_end;
  logic s_rise, s_bit;
  logic rise_sel, bit_sel, done, ovr_set, load;
  logic [BYTE_W-1:0] shift_word;

  assign data_rd = host_rd && (host_addr == SEL_DATA);
  assign stat_wr = host_wr && (host_addr == SEL_STAT);
  assign ctrl_wr = host_wr && (host_addr == SEL_CTRL);
  assign ovr_clr = stat_wr && !host_wdata[STS_OVR];

  assign m_abort = !ctrl.en || !ctrl.master || ovr;
  assign m_start = data_rd && ctrl.en && ctrl.master && !ovr && !halted && !m_busy;

  ssrx_sclk_gen #(.DIV_HALF(DIV_HALF), .FRAME_BITS(BYTE_W)) u_sclk (
    .clk(clk), .rst_n(rst_n), .abort(m_abort), .start(m_start),
    .busy(m_busy), .sck(m_sck), .rise(m_rise), .frame_end(m_end)
  );

  ssrx_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_in(sck_in), .sdi_in(sdi),
    .rise(s_rise), .bit_o(s_bit)
  );

  assign rise_sel = ctrl.master ? m_rise : s_rise;
  assign bit_sel  = ctrl.master ? sdi    : s_bit;

  ssrx_shifter #(.FRAME_BITS(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(!ctrl.en), .hold(ovr),
    .rise(rise_sel), .bit_in(bit_sel), .done(done), .word(shift_word)
  );

  // completion with unread data and no simultaneous read is an overrun
  assign ovr_set = done && full && !data_rd;
  assign load    = done && !ovr_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      rx_data  <= '0;
      full     <= 1'b0;
      ovr      <= 1'b0;
      halted   <= 1'b0;
      last_frm <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(host_wdata[CTRL_W-1:0]);

      if (load) begin
        rx_data <= shift_word;
        full    <= 1'b1;
      end else if (data_rd) begin
        full <= 1'b0;
      end

      if (ovr_set)      ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;

      if (m_start) last_frm <= ctrl.stop;

      if (!ctrl.en || !ctrl.stop)   halted <= 1'b0;
      else if (m_end && last_frm)   halted <= 1'b1;
    end
  end

  always_comb begin
    unique case (host_addr)
      SEL_DATA: host_rdata = rx_data;
      SEL_STAT: host_rdata = {6'b0, ovr, full};
      SEL_CTRL: host_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl};
      default:  host_rdata = '0;
    endcase
  end

  assign sck_oe  = ctrl.en && ctrl.master;
  assign sck_out = m_sck;
  assign irq_rx  = full && ctrl.rxie;
  assign irq_ovr = ovr && ctrl.ovie;

  // R1
  load_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (!full || data_rd) |=> full && (rx_data == $past(shift_word)));

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && !done |=> !full);

  // R6
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && full && !data_rd |=> ovr && $stable(rx_data));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !ovr_clr |=> ovr);

  // R7
  no_frame_in_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !done);

  // R5
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !m_busy && !m_start);
endmodule

// File: tb/ssrx_ctrl_test.sv
`timescale 1ns/1ps
module ssrx_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sck_in = 1'b1, sck_out, sck_oe, sdi = 1'b0, irq_rx, irq_ovr;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];

  bit        mst_model = 1'b0;
  logic [7:0] mbyte = '0;
  int        midx = 0;
  int        pulses = 0;
  longint    last_rise = 0, min_gap = 1000000;

  always #4 clk = ~clk;

  ssrx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi),
    .irq_rx(irq_rx), .irq_ovr(irq_ovr)
  );

  // external slave model for master mode: shift out on falling clock
  always @(negedge sck_out) begin
    if (mst_model && midx < 8) begin
      sdi = mbyte[7 - midx];
      midx++;
    end
  end

  always @(posedge sck_out) begin
    if (pulses > 0 && ($time - last_rise) < min_gap) min_gap = $time - last_rise;
    last_rise = $time;
    pulses++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  // monitor side of the scoreboard: pop the expected byte and compare
  task automatic rd_chk(input string req);
    logic [7:0] d, e;
    bus_rd(2'd0, d);
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    chk(d === e, req, d, e);
  endtask

  task automatic stat_chk(input logic [7:0] e, input string req);
    logic [7:0] d;
    bus_rd(2'd1, d);
    chk(d === e, req, d, e);
  endtask

  // driver side: slave-mode frame, optional read on the completing edge
  task automatic s_send(input logic [7:0] b, input bit push, input bit collide,
                        output logic [7:0] col_rd);
    col_rd = '0;
    if (push) exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      sck_in = 1'b0; sdi = b[i];
      repeat (3) @(negedge clk);
      sck_in = 1'b1;
      if (i == 0 && collide) begin
        repeat (2) @(negedge clk);
        host_addr = 2'd0; host_rd = 1'b1;
        #1 col_rd = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
      end else begin
        repeat (3) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic m_frame_rd(input logic [7:0] next_b, input bit push, output logic [7:0] d);
    mbyte = next_b; midx = 0;
    if (push) exp_q.push_back(next_b);
    bus_rd(2'd0, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, col, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;

    // R10 reset state
    stat_chk(8'h00, "R10 status");
    bus_rd(2'd2, d); chk(d === 8'h00, "R10 control", d, 0);
    chk(sck_out === 1'b1 && sck_oe === 1'b0, "R10 clock pins", {sck_out, sck_oe}, 2'b10);
    chk(irq_rx === 1'b0 && irq_ovr === 1'b0, "R10 irqs", {irq_rx, irq_ovr}, 0);

    // ---- master mode ----
    mst_model = 1'b1;
    bus_wr(2'd2, 8'h03);
    chk(sck_oe === 1'b1, "R4 oe in master", sck_oe, 1);
    m_frame_rd(8'hA5, 1'b1, d);               // dummy read starts first frame
    repeat (40) @(negedge clk);
    chk(pulses == 8, "R4 eight pulses", pulses, 8);
    chk(min_gap == 32, "R4 period 4 clocks", int'(min_gap), 32);
    stat_chk(8'h01, "R1 full after frame");
    m_frame_rd(8'h3C, 1'b0, d);               // returns A5, starts next
    e = exp_q.pop_front(); exp_q.push_back(8'h3C);
    chk(d === e, "R1 master byte msb first", d, e);
    bus_rd(2'd0, d);                          // busy: must start nothing
    repeat (40) @(negedge clk);
    chk(pulses == 16, "R4 read while busy ignored", pulses, 16);
    chk(sck_out === 1'b1, "R4 idle high", sck_out, 1);

    bus_wr(2'd2, 8'h07);                      // stop requested
    m_frame_rd(8'hC3, 1'b0, d);
    e = exp_q.pop_front(); exp_q.push_back(8'hC3);
    chk(d === e, "R5 byte before last", d, e);
    repeat (40) @(negedge clk);
    chk(pulses == 24, "R5 last frame clocked", pulses, 24);
    rd_chk("R5 final byte");
    repeat (40) @(negedge clk);
    chk(pulses == 24, "R5 no clocks after stop", pulses, 24);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd0, d);
    repeat (20) @(negedge clk);
    chk(pulses == 24 && sck_oe === 1'b0, "R5 disabled read quiet", pulses, 24);

    // R9 master abort mid-frame
    bus_wr(2'd2, 8'h03);
    m_frame_rd(8'hFF, 1'b0, d);
    repeat (9) @(negedge clk);
    bus_wr(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    chk(sck_out === 1'b1 && sck_oe === 1'b0, "R9 master abort clock high", {sck_out, sck_oe}, 2'b10);
    stat_chk(8'h00, "R9 no byte from aborted frame");
    mst_model = 1'b0;

    // ---- slave mode ----
    bus_wr(2'd2, 8'h09);                      // en + rxie
    chk(sck_oe === 1'b0, "R8 oe in slave", sck_oe, 0);
    s_send(8'h5A, 1'b1, 1'b0, col);
    chk(irq_rx === 1'b1, "R2 irq on full", irq_rx, 1);
    rd_chk("R8 slave byte");
    chk(irq_rx === 1'b0, "R3 read clears full", irq_rx, 0);

    // R3 collision: read on the completing edge
    s_send(8'h6B, 1'b1, 1'b0, col);
    s_send(8'h9C, 1'b1, 1'b1, col);
    e = exp_q.pop_front();
    chk(col === e, "R3 collide read old byte", col, e);
    stat_chk(8'h01, "R3 full kept no overrun");
    rd_chk("R3 new byte after collision");

    // R6 / R7 overrun
    bus_wr(2'd2, 8'h19);
    s_send(8'h11, 1'b1, 1'b0, col);
    s_send(8'h22, 1'b0, 1'b0, col);
    stat_chk(8'h03, "R6 overrun flag");
    chk(irq_ovr === 1'b1, "R6 overrun irq", irq_ovr, 1);
    rd_chk("R6 old byte kept");
    s_send(8'h33, 1'b0, 1'b0, col);
    stat_chk(8'h02, "R7 no frame during overrun");
    bus_wr(2'd1, 8'h02);
    stat_chk(8'h02, "R7 write one keeps flag");
    bus_wr(2'd1, 8'h00);
    stat_chk(8'h00, "R7 write zero clears");
    chk(irq_ovr === 1'b0, "R7 irq drops", irq_ovr, 0);
    s_send(8'h44, 1'b1, 1'b0, col);
    rd_chk("R7 reception resumes");

    // R9 slave partial frame discarded
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sck_in = 1'b0; sdi = 1'b1;
      repeat (3) @(negedge clk); sck_in = 1'b1;
      repeat (3) @(negedge clk);
    end
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd2, 8'h09);
    s_send(8'hE7, 1'b1, 1'b0, col);
    rd_chk("R9 count reset after disable");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule